// File: doc/BRIEF.md
# Smart-Card Contact Power Sequencer

This block powers the contact set of one smart-card slot up and down in a fixed order. The host requests a session by writing a one to the start bit. The request is accepted only while the supply is good, a card sits in the slot and neither protection fault is raised. The sequencer then starts the voltage converter and the card supply. After that it releases the data line high and starts the clock. Finally it hands the reset contact to the host.

A session ends in one of two ways. The host may write a zero to the start bit. Otherwise the environment fails: the card is pulled out, the supply drops or a protection fault appears. In both cases the sequencer walks down a timed shutdown. Reset goes low first, then the clock stops, then the data and auxiliary contacts go low, then the card supply is removed, and last the converter is stopped. An environment failure also clears the start bit and pulses an interrupt.

The spacing between steps is measured in ticks of an external timing strobe. The slew of the card supply is analog and lies outside this block. Here it is only an enable output followed by a wait step.

Top module: `card_contact_seq`

## Requirements
- R1: After reset, and whenever `seq_idle` is 1, the outputs `conv_en`, `vcc_en`, `io_en`, `clk_en`, `rst_out`, `c4_out`, `c8_out` and `start_bit` are all 0.
- R2: A cycle with `start_wr`=1 and `start_wdata`=1 while idle is accepted only if `supply_ok`=1, `card_present`=1, `vcc_fault`=0 and `rst_fault`=0. A refused request leaves `start_bit` at 0 and every contact output unchanged.
- R3: On the accepting edge, `start_bit`, `conv_en` and `vcc_en` rise. One step later `io_en` rises, and from then on `c4_out`/`c8_out` copy `c4_req`/`c8_req` with one cycle of delay. One more step later `clk_en` rises. After a third step the session is on, and `rst_out` copies `rst_req` with one cycle of delay.
- R4: On the edge that triggers shutdown, `rst_out` goes to 0. One step later `clk_en` goes to 0. One more step later `io_en`, `c4_out` and `c8_out` go to 0. Then `vcc_en` goes to 0, and one step after that `conv_en` goes to 0 and `seq_idle` goes to 1.
- R5: A step ends on the edge where `tick`=1 and the number of ticked edges since the step began reaches the effective gap. The effective gap is `step_gap`, or 4 when `step_gap` is 0.
- R6: `prot_flag` is the OR of `vcc_fault` and `rst_fault`.
- R7: A cycle with `start_wr`=1 and `start_wdata`=0 during power-up or an active session starts shutdown and clears `start_bit` on that edge, with no `abort_irq`.
- R8: During power-up or an active session, each of `card_present`=0, `supply_ok`=0 or `prot_flag`=1 starts shutdown and clears `start_bit` on that edge. `abort_irq` is 1 for exactly the following cycle.
- R9: Start requests made during shutdown are ignored: `start_bit` stays 0 until `seq_idle` is 1.
- R10: During shutdown no contact output goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing strobe that paces the steps |
| step_gap | input | GAP_W | Ticks per step (0 selects 4) |
| start_wr | input | 1 | Host write strobe for the start bit |
| start_wdata | input | 1 | Value written to the start bit |
| rst_req | input | 1 | Host reset level, used while a session is on |
| c4_req | input | 1 | Host level for auxiliary contact C4 |
| c8_req | input | 1 | Host level for auxiliary contact C8 |
| card_present | input | 1 | Card detected in the slot |
| supply_ok | input | 1 | Supply supervisor reports good |
| vcc_fault | input | 1 | Overcurrent on the card supply pin |
| rst_fault | input | 1 | Overcurrent on the reset pin |
| conv_en | output | 1 | Voltage converter run |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Data line released high (0 = held low) |
| clk_en | output | 1 | Card clock running |
| rst_out | output | 1 | Card reset contact level |
| c4_out | output | 1 | C4 contact level |
| c8_out | output | 1 | C8 contact level |
| start_bit | output | 1 | Session requested and running |
| prot_flag | output | 1 | Protection fault for the slot |
| abort_irq | output | 1 | One-cycle pulse on an automatic shutdown |
| seq_idle | output | 1 | Fully inactive, ready for a new request |

## Verification
The bench goes after the cases where an ordering or a timing rule is easy to get wrong. A zero gap must mean four ticks. A zero gap taken literally would leave a step that never ends, or would skip it. A stop request that also raises the interrupt, or a failure that does not clear the start bit, shows up on `abort_irq` and `start_bit`. The bench removes the card during power-up, before the clock has started. A design that re-applies every contact during shutdown would then start the clock it should be stopping. A repeated start request during shutdown is also exercised. A design that re-arms early would raise `start_bit` before `seq_idle`.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  localparam int unsigned DEFAULT_GAP = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_VCC,
    ST_UP_IO,
    ST_UP_CLK,
    ST_ON,
    ST_DN_RST,
    ST_DN_CLK,
    ST_DN_IO,
    ST_DN_VCC
  } seq_state_e;

  typedef struct packed {
    logic conv;
    logic vcc;
    logic io;
    logic clk;
    logic rst;
    logic c4;
    logic c8;
  } contact_t;

  // Gap value 0 selects the default spacing.
  function automatic int unsigned eff_gap(input int unsigned g);
    return (g == 0) ? DEFAULT_GAP : g;
  endfunction

  // True when one more tick completes the step.
  function automatic logic step_reached(input int unsigned cnt, input int unsigned g);
    return (cnt + 32'd1) >= eff_gap(g);
  endfunction

  function automatic logic prot_of(input logic vf, input logic rf);
    return vf | rf;
  endfunction

  // States in which the slot is being powered or is in session.
  function automatic logic is_live(input seq_state_e s);
    return (s == ST_UP_VCC) || (s == ST_UP_IO) || (s == ST_UP_CLK) || (s == ST_ON);
  endfunction

  // States that end on a tick count.
  function automatic logic is_timed(input seq_state_e s);
    return (s != ST_IDLE) && (s != ST_ON);
  endfunction

  // States in which C4/C8 copy the host levels.
  function automatic logic follows_host(input seq_state_e s);
    return (s == ST_UP_IO) || (s == ST_UP_CLK) || (s == ST_ON);
  endfunction

endpackage

// File: rtl/ccs_step_timer.sv
module ccs_step_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [GAP_W-1:0] gap,
  output logic             done
);
  import ccs_pkg::*;

  logic [GAP_W-1:0] cnt_q;

  assign done = run && tick && step_reached(32'(cnt_q), 32'(gap));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ccs_fsm.sv
module ccs_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_wr,
  input  logic                start_wdata,
  input  logic                card_present,
  input  logic                supply_ok,
  input  logic                prot,
  input  logic                step_done,
  output ccs_pkg::seq_state_e state_q,
  output ccs_pkg::seq_state_e state_d,
  output logic                state_move,
  output logic                start_bit,
  output logic                abort_irq
);
  import ccs_pkg::*;

  logic env_ok;
  logic host_set;
  logic host_clr;
  logic ev_accept;
  logic ev_abort;
  logic ev_stop;
  logic ev_trigger;

  assign env_ok     = supply_ok && card_present && !prot;
  assign host_set   = start_wr && start_wdata;
  assign host_clr   = start_wr && !start_wdata;
  assign ev_accept  = (state_q == ST_IDLE) && host_set && env_ok;
  assign ev_abort   = is_live(state_q) && !env_ok;
  assign ev_stop    = is_live(state_q) && env_ok && host_clr;
  assign ev_trigger = ev_abort || ev_stop;
  assign state_move = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (ev_accept) state_d = ST_UP_VCC;
      ST_UP_VCC: if (ev_trigger) state_d = ST_DN_RST;
                 else if (step_done) state_d = ST_UP_IO;
      ST_UP_IO:  if (ev_trigger) state_d = ST_DN_RST;
                 else if (step_done) state_d = ST_UP_CLK;
      ST_UP_CLK: if (ev_trigger) state_d = ST_DN_RST;
                 else if (step_done) state_d = ST_ON;
      ST_ON:     if (ev_trigger) state_d = ST_DN_RST;
      ST_DN_RST: if (step_done) state_d = ST_DN_CLK;
      ST_DN_CLK: if (step_done) state_d = ST_DN_IO;
      ST_DN_IO:  if (step_done) state_d = ST_DN_VCC;
      ST_DN_VCC: if (step_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      start_bit <= 1'b0;
      abort_irq <= 1'b0;
    end else begin
      state_q   <= state_d;
      abort_irq <= ev_abort;
      if (ev_accept) start_bit <= 1'b1;
      else if (ev_trigger) start_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/ccs_contacts.sv
module ccs_contacts (
  input  logic                clk,
  input  logic                rst_n,
  input  ccs_pkg::seq_state_e state_q,
  input  ccs_pkg::seq_state_e state_d,
  input  logic                state_move,
  input  logic                rst_req,
  input  logic                c4_req,
  input  logic                c8_req,
  output ccs_pkg::contact_t   pins
);
  import ccs_pkg::*;

  logic follow_aux;
  logic follow_rst;

  assign follow_aux = follows_host(state_d);
  assign follow_rst = (state_q == ST_ON) && (state_d == ST_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins <= '0;
    end else begin
      if (state_move) begin
        case (state_d)
          ST_UP_VCC: begin pins.conv <= 1'b1; pins.vcc <= 1'b1; end
          ST_UP_IO:  pins.io  <= 1'b1;
          ST_UP_CLK: pins.clk <= 1'b1;
          ST_DN_RST: pins.rst <= 1'b0;
          ST_DN_CLK: pins.clk <= 1'b0;
          ST_DN_IO:  begin pins.io <= 1'b0; pins.c4 <= 1'b0; pins.c8 <= 1'b0; end
          ST_DN_VCC: pins.vcc <= 1'b0;
          ST_IDLE:   pins.conv <= 1'b0;
          default: ;
        endcase
      end
      if (follow_aux) begin
        pins.c4 <= c4_req;
        pins.c8 <= c8_req;
      end
      if (follow_rst) pins.rst <= rst_req;
    end
  end
endmodule

// File: rtl/card_contact_seq.sv
module card_contact_seq #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [GAP_W-1:0] step_gap,
  input  logic             start_wr,
  input  logic             start_wdata,
  input  logic             rst_req,
  input  logic             c4_req,
  input  logic             c8_req,
  input  logic             card_present,
  input  logic             supply_ok,
  input  logic             vcc_fault,
  input  logic             rst_fault,
  output logic             conv_en,
  output logic             vcc_en,
  output logic             io_en,
  output logic             clk_en,
  output logic             rst_out,
  output logic             c4_out,
  output logic             c8_out,
  output logic             start_bit,
  output logic             prot_flag,
  output logic             abort_irq,
  output logic             seq_idle
);
  import ccs_pkg::*;

  seq_state_e state_q;
  seq_state_e state_d;
  logic       state_move;
  logic       step_done;
  contact_t   pins;

  assign prot_flag = prot_of(vcc_fault, rst_fault);

  ccs_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_wr     (start_wr),
    .start_wdata  (start_wdata),
    .card_present (card_present),
    .supply_ok    (supply_ok),
    .prot         (prot_flag),
    .step_done    (step_done),
    .state_q      (state_q),
    .state_d      (state_d),
    .state_move   (state_move),
    .start_bit    (start_bit),
    .abort_irq    (abort_irq)
  );

  ccs_step_timer #(.GAP_W(GAP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (is_timed(state_q)),
    .restart (state_move),
    .tick    (tick),
    .gap     (step_gap),
    .done    (step_done)
  );

  ccs_contacts u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .state_d    (state_d),
    .state_move (state_move),
    .rst_req    (rst_req),
    .c4_req     (c4_req),
    .c8_req     (c8_req),
    .pins       (pins)
  );

  assign conv_en  = pins.conv;
  assign vcc_en   = pins.vcc;
  assign io_en    = pins.io;
  assign clk_en   = pins.clk;
  assign rst_out  = pins.rst;
  assign c4_out   = pins.c4;
  assign c8_out   = pins.c8;
  assign seq_idle = (state_q == ST_IDLE);
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker (
  input logic clk,
  input logic rst_n,
  input logic start_wr,
  input logic start_wdata,
  input logic card_present,
  input logic supply_ok,
  input logic vcc_fault,
  input logic rst_fault,
  input logic conv_en,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic rst_out,
  input logic c4_out,
  input logic c8_out,
  input logic start_bit,
  input logic abort_irq,
  input logic seq_idle
);
  logic env_good;
  assign env_good = supply_ok && card_present && !vcc_fault && !rst_fault;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> !(conv_en || vcc_en || io_en || clk_en || rst_out || c4_out || c8_out || start_bit)); // R1
  AST_REFUSE_BAD_ENV: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !env_good) |=> !start_bit); // R2
  AST_IO_AFTER_VCC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_en) |-> vcc_en); // R3
  AST_CLK_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (vcc_en && io_en)); // R3
  AST_RST_DROPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_bit) |-> !rst_out); // R4
  AST_CLK_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> !rst_out); // R4
  AST_IO_LOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_en) |-> (!clk_en && !rst_out)); // R4
  AST_VCC_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> (!io_en && !clk_en && !c4_out && !c8_out)); // R4
  AST_HOST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && env_good && start_wr && !start_wdata) |=> (!start_bit && !abort_irq && !rst_out)); // R7
  AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && !env_good) |=> (!start_bit && abort_irq)); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_irq |=> !abort_irq); // R8
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_bit && !seq_idle) |=> !start_bit); // R9
endmodule

bind card_contact_seq ccs_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_wr     (start_wr),
  .start_wdata  (start_wdata),
  .card_present (card_present),
  .supply_ok    (supply_ok),
  .vcc_fault    (vcc_fault),
  .rst_fault    (rst_fault),
  .conv_en      (conv_en),
  .vcc_en       (vcc_en),
  .io_en        (io_en),
  .clk_en       (clk_en),
  .rst_out      (rst_out),
  .c4_out       (c4_out),
  .c8_out       (c8_out),
  .start_bit    (start_bit),
  .abort_irq    (abort_irq),
  .seq_idle     (seq_idle)
);

// File: tb/card_contact_seq_test.sv
`timescale 1ns/1ps
module card_contact_seq_test;
  localparam int GAP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [GAP_W-1:0] step_gap = '0;
  logic start_wr = 1'b0, start_wdata = 1'b0;
  logic rst_req = 1'b0, c4_req = 1'b0, c8_req = 1'b0;
  logic card_present = 1'b1, supply_ok = 1'b1, vcc_fault = 1'b0, rst_fault = 1'b0;
  logic conv_en, vcc_en, io_en, clk_en, rst_out, c4_out, c8_out;
  logic start_bit, prot_flag, abort_irq, seq_idle;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  card_contact_seq #(.GAP_W(GAP_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_gap(step_gap),
    .start_wr(start_wr), .start_wdata(start_wdata),
    .rst_req(rst_req), .c4_req(c4_req), .c8_req(c8_req),
    .card_present(card_present), .supply_ok(supply_ok),
    .vcc_fault(vcc_fault), .rst_fault(rst_fault),
    .conv_en(conv_en), .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en),
    .rst_out(rst_out), .c4_out(c4_out), .c8_out(c8_out),
    .start_bit(start_bit), .prot_flag(prot_flag), .abort_irq(abort_irq),
    .seq_idle(seq_idle)
  );

  // Reference model of the requirements: phase 0 idle, 1..3 power-up,
  // 4 session on, 5..8 shutdown steps.
  int m_ph, m_cnt;
  bit m_conv, m_vcc, m_io, m_clk, m_rst, m_c4, m_c8, m_start, m_irq;
  int g_eff;
  bit env_v, td;

  function automatic int gap_rule(input int g);
    return (g == 0) ? 4 : g;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0;
      {m_conv, m_vcc, m_io, m_clk, m_rst, m_c4, m_c8, m_start, m_irq} = '0;
    end else begin
      env_v = supply_ok && card_present && !vcc_fault && !rst_fault;
      g_eff = gap_rule(int'(step_gap));
      td = tick && (m_cnt + 1 >= g_eff);
      m_irq = 0;
      if (m_ph == 0) begin
        if (start_wr && start_wdata && env_v) begin
          m_ph = 1; m_vcc = 1; m_conv = 1; m_start = 1; m_cnt = 0;
        end
      end else if (m_ph <= 4 && (!env_v || (start_wr && !start_wdata))) begin
        m_irq = !env_v; m_ph = 5; m_start = 0; m_rst = 0; m_cnt = 0;
      end else if (m_ph == 4) begin
        m_c4 = c4_req; m_c8 = c8_req; m_rst = rst_req;
      end else if (td) begin
        m_cnt = 0;
        case (m_ph)
          1: begin m_ph = 2; m_io = 1; m_c4 = c4_req; m_c8 = c8_req; end
          2: begin m_ph = 3; m_clk = 1; m_c4 = c4_req; m_c8 = c8_req; end
          3: begin m_ph = 4; m_c4 = c4_req; m_c8 = c8_req; end
          5: begin m_ph = 6; m_clk = 0; end
          6: begin m_ph = 7; m_io = 0; m_c4 = 0; m_c8 = 0; end
          7: begin m_ph = 8; m_vcc = 0; end
          default: begin m_ph = 0; m_conv = 0; end
        endcase
      end else begin
        if (tick) m_cnt = m_cnt + 1;
        if (m_ph == 2 || m_ph == 3) begin m_c4 = c4_req; m_c8 = c8_req; end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  logic [6:0] prev_pins = '0;

  task automatic cmp_all();
    logic [6:0] now_pins;
    check("R1 conv_en", conv_en, m_conv);
    check("R4 vcc_en", vcc_en, m_vcc);
    check("R4 io_en", io_en, m_io);
    check("R4 clk_en", clk_en, m_clk);
    check("R3 rst_out", rst_out, m_rst);
    check("R3 c4_out", c4_out, m_c4);
    check("R3 c8_out", c8_out, m_c8);
    check("R2 start_bit", start_bit, m_start);
    check("R8 abort_irq", abort_irq, m_irq);
    check("R6 prot_flag", prot_flag, vcc_fault | rst_fault);
    check("R9 seq_idle", seq_idle, m_ph == 0);
    now_pins = {conv_en, vcc_en, io_en, clk_en, rst_out, c4_out, c8_out};
    if (m_ph >= 5)
      check("R10 no rise in shutdown", int'((now_pins & ~prev_pins) != 0), 0);
    prev_pins = now_pins;
  endtask

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic write_start(input bit v);
    start_wr = 1; start_wdata = v;
    cyc();
    start_wr = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1: reset state
    check("R1 reset quiet", int'({conv_en, vcc_en, io_en, clk_en, rst_out, c4_out, c8_out, start_bit}), 0);
    check("R1 reset idle", seq_idle, 1);

    // R2: refused while no card
    card_present = 0;
    write_start(1);
    check("R2 refused start_bit", start_bit, 0);
    check("R2 refused vcc_en", vcc_en, 0);
    card_present = 1;
    cyc();

    // R3/R5: power-up with gap 0 (four ticks), tick every cycle
    step_gap = 0; tick = 1; rst_req = 1; c4_req = 1;
    write_start(1);
    check("R3 vcc on accept", vcc_en, 1);
    cyc(3);
    check("R5 io still low after 3 ticks", io_en, 0);
    cyc();
    check("R5 io high after 4 ticks", io_en, 1);
    cyc();
    check("R3 c4 follows host", c4_out, 1);
    cyc(3);
    check("R3 clk on", clk_en, 1);
    cyc(4);
    check("R3 rst held on entry", rst_out, 0);
    cyc();
    check("R3 rst follows host", rst_out, 1);

    // R7/R9: host stop, then a start request during shutdown
    write_start(0);
    check("R7 rst low at stop", rst_out, 0);
    check("R7 no irq", abort_irq, 0);
    write_start(1);
    check("R9 start ignored", start_bit, 0);
    cyc(2);
    check("R4 clk still on", clk_en, 1);
    cyc();
    check("R4 clk stopped", clk_en, 0);
    cyc(4);
    check("R4 io low", io_en, 0);
    check("R4 vcc still on", vcc_en, 1);
    cyc(4);
    check("R4 vcc off", vcc_en, 0);
    check("R4 conv still on", conv_en, 1);
    cyc(4);
    check("R1 idle after shutdown", seq_idle, 1);
    check("R1 conv off", conv_en, 0);

    // R8: protection fault during session
    write_start(1);
    cyc(13);
    rst_fault = 1;
    #1;
    check("R6 prot from rst fault", prot_flag, 1);
    cyc();
    check("R8 start cleared", start_bit, 0);
    check("R8 irq pulse", abort_irq, 1);
    rst_fault = 0;
    cyc();
    check("R8 irq one cycle", abort_irq, 0);
    cyc(16);
    check("R8 back to idle", seq_idle, 1);

    // R10: card removed during power-up, before the clock starts
    write_start(1);
    cyc(5);
    card_present = 0;
    cyc();
    check("R10 io kept", io_en, 1);
    check("R10 clk not started", clk_en, 0);
    check("R8 irq on removal", abort_irq, 1);
    card_present = 1;
    cyc(20);
    check("R10 idle after removal", seq_idle, 1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 300 == 0) step_gap = GAP_W'($urandom % 4);
      tick = ($urandom % 3) == 0;
      start_wr = ($urandom % 12) == 0;
      start_wdata = ($urandom % 3) != 0;
      rst_req = 1'($urandom);
      c4_req = 1'($urandom);
      c8_req = 1'($urandom);
      card_present = ($urandom % 150) != 0;
      supply_ok = ($urandom % 200) != 0;
      vcc_fault = ($urandom % 250) == 0;
      rst_fault = ($urandom % 250) == 0;
      cyc();
    end

    fin = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule